// File: doc/BRIEF.md
# CAN Time-Reference Payload Inserter

This block sits between a transmit mailbox and the bit serializer of a CAN controller. The serializer fetches the data field one byte at a time. The block either returns the mailbox byte unchanged or replaces it with a time value, which turns the outgoing frame into a time-master reference message. The time value is a 16-bit free-running timer and a 4-bit cycle counter, both sampled at the frame's own start of frame.

At every start-of-frame strobe the block samples and holds a frame context. The context holds three things. The first is whether insertion is armed: the mailbox is set for transmit, its time-reference enable is set and its DLC is 4. The second is the timer and cycle-count values. The third is the byte order to use for the timer. This context stays constant until the next start of frame. A retransmission after lost arbitration therefore carries a freshly sampled value. When the frame is armed, the cycle count fills the low nibble of byte 0, and the timer fills bytes 1 and 2. Every other bit and byte comes from the mailbox.

Top module: `tref_inserter`

## Requirements
- R1: After reset, ser_valid is 0 and ser_byte is 0x00. Until the first start of frame, every requested byte passes through unchanged.
- R2: Insertion is armed at a start of frame only if tx_mode=1, tref_en=1 and dlc=4 at that edge. Otherwise all bytes of that frame pass through unchanged.
- R3: In an armed frame, data bytes 1 and 2 carry the timer value sampled in the sof cycle. Later timer changes do not alter them until the next start of frame.
- R4: The byte order is taken from big_end in the sof cycle. With big_end=1, byte 1 holds timer[15:8] and byte 2 holds timer[7:0]. With big_end=0, byte 1 holds timer[7:0] and byte 2 holds timer[15:8].
- R5: In an armed frame, byte 0 bits 3:0 hold the cycle count sampled at start of frame. Bits 7:4 come from the mailbox byte.
- R6: In an armed frame, byte index 3 and indices 4 to 7 pass through unchanged.
- R7: ser_valid is 1 exactly one cycle after a cycle with byte_req=1, and 0 otherwise. ser_byte is updated in that same cycle and holds its value between requests.
- R8: Each new start of frame, such as a retransmission, re-samples the timer, the cycle count, the arming condition and the byte order.
- R9: Changes to tx_mode, tref_en, dlc or big_end after the start of frame have no effect on the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_mode | input | 1 | Mailbox configured for transmission |
| tref_en | input | 1 | Mailbox time-reference insertion enable |
| dlc | input | 4 | Data length code of the mailbox frame |
| big_end | input | 1 | Timer byte order: 1 = high byte first |
| timer | input | 16 | Free-running timer |
| cyc_cnt | input | 4 | Cycle counter |
| sof | input | 1 | Start-of-frame strobe, one cycle |
| byte_req | input | 1 | Serializer requests a data byte |
| byte_idx | input | 3 | Index of the requested data byte |
| mb_byte | input | 8 | Mailbox content for byte_idx |
| ser_valid | output | 1 | ser_byte was updated this cycle |
| ser_byte | output | 8 | Byte handed to the serializer |

## Verification
The frame context is loaded at the clock edge that sees sof=1, so it is used by any request made from the next cycle on. A byte request is answered one cycle later. The bench drives sof on a falling edge and then scrambles timer, cycle count and configuration. It raises byte_req on a later falling edge and samples ser_valid and ser_byte on the falling edge after the next rising edge. One cycle later it confirms that ser_valid has dropped. Requests made after a configuration change or a second start of frame show that the context changes only at start of frame.

// File: rtl/tref_pkg.sv
package tref_pkg;
  localparam int unsigned TREF_BYTE_W = 8;
  localparam int unsigned TREF_TMR_W  = 16;
  localparam int unsigned TREF_CYC_W  = 4;
  localparam int unsigned TREF_DLC_W  = 4;
  localparam int unsigned TREF_IDX_W  = 3;
  localparam int unsigned TREF_DLC    = 4;  // only this length is stamped
  localparam int unsigned TREF_CYC_POS   = 0;  // byte carrying the cycle count
  localparam int unsigned TREF_STAMP_POS = 1;  // first byte of the timer

  typedef enum logic {
    END_LITTLE = 1'b0,
    END_BIG    = 1'b1
  } tref_endian_e;
endpackage

// File: rtl/tref_rst_sync.sv
module tref_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tref_capture.sv
module tref_capture
  import tref_pkg::*;
#(
  parameter int unsigned TMR_W    = TREF_TMR_W,
  parameter int unsigned CYC_W    = TREF_CYC_W,
  parameter int unsigned DLC_W    = TREF_DLC_W,
  parameter int unsigned DLC_STAMP = TREF_DLC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             tx_mode,
  input  logic             tref_en,
  input  logic [DLC_W-1:0] dlc,
  input  logic             big_end,
  input  logic [TMR_W-1:0] timer,
  input  logic [CYC_W-1:0] cyc_cnt,
  output logic             armed,
  output tref_endian_e     order,
  output logic [TMR_W-1:0] stamp,
  output logic [CYC_W-1:0] cyc
);
  localparam logic [DLC_W-1:0] DLC_MATCH = DLC_W'(DLC_STAMP);

  logic             armed_d, armed_q;
  tref_endian_e     order_d, order_q;
  logic [TMR_W-1:0] stamp_d, stamp_q;
  logic [CYC_W-1:0] cyc_d,   cyc_q;

  // next state: the whole frame context is taken only at start of frame
  always_comb begin
    armed_d = armed_q;
    order_d = order_q;
    stamp_d = stamp_q;
    cyc_d   = cyc_q;
    if (sof) begin
      armed_d = tx_mode && tref_en && (dlc == DLC_MATCH);
      order_d = big_end ? END_BIG : END_LITTLE;
      stamp_d = timer;
      cyc_d   = cyc_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      order_q <= END_LITTLE;
      stamp_q <= '0;
      cyc_q   <= '0;
    end else begin
      armed_q <= armed_d;
      order_q <= order_d;
      stamp_q <= stamp_d;
      cyc_q   <= cyc_d;
    end
  end

  assign armed = armed_q;
  assign order = order_q;
  assign stamp = stamp_q;
  assign cyc   = cyc_q;

  // R3, R9: context frozen between start-of-frame strobes
  a_r3_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> ($stable(stamp_q) && $stable(cyc_q) && $stable(armed_q) && $stable(order_q)));

  // R2: arming follows the three conditions seen in the sof cycle
  a_r2_arm_rule: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (armed_q == ($past(tx_mode) && $past(tref_en) && ($past(dlc) == DLC_MATCH))));

  // R8: each start of frame re-samples the timer
  a_r8_resample: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (stamp_q == $past(timer)));
endmodule

// File: rtl/tref_byte_mux.sv
module tref_byte_mux
  import tref_pkg::*;
#(
  parameter int unsigned BYTE_W    = TREF_BYTE_W,
  parameter int unsigned TMR_W     = TREF_TMR_W,
  parameter int unsigned CYC_W     = TREF_CYC_W,
  parameter int unsigned IDX_W     = TREF_IDX_W,
  parameter int unsigned CYC_POS   = TREF_CYC_POS,
  parameter int unsigned STAMP_POS = TREF_STAMP_POS
) (
  input  logic              armed,
  input  tref_endian_e      order,
  input  logic [TMR_W-1:0]  stamp,
  input  logic [CYC_W-1:0]  cyc,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] mb_byte,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int unsigned TMR_BYTES = TMR_W / BYTE_W;
  localparam logic [IDX_W-1:0] CYC_IDX = IDX_W'(CYC_POS);

  logic [TMR_BYTES-1:0]             lane_hit;
  logic [TMR_BYTES-1:0][BYTE_W-1:0] lane_val;

  // one substitution lane per timer byte; order picks the timer slice
  for (genvar k = 0; k < TMR_BYTES; k++) begin : g_lane
    localparam int unsigned POS    = STAMP_POS + k;
    localparam int unsigned HI_SEL = TMR_BYTES - 1 - k;
    assign lane_hit[k] = (idx == IDX_W'(POS));
    assign lane_val[k] = (order == END_BIG) ? stamp[HI_SEL*BYTE_W +: BYTE_W]
                                            : stamp[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    out_byte = mb_byte;
    if (armed) begin
      if (idx == CYC_IDX) out_byte = {mb_byte[BYTE_W-1:CYC_W], cyc};
      for (int k = 0; k < TMR_BYTES; k++) begin
        if (lane_hit[k]) out_byte = lane_val[k];
      end
    end
  end
endmodule

// File: rtl/tref_inserter.sv
module tref_inserter
  import tref_pkg::*;
#(
  parameter int unsigned BYTE_W    = TREF_BYTE_W,
  parameter int unsigned TMR_W     = TREF_TMR_W,
  parameter int unsigned CYC_W     = TREF_CYC_W,
  parameter int unsigned DLC_W     = TREF_DLC_W,
  parameter int unsigned IDX_W     = TREF_IDX_W,
  parameter int unsigned DLC_STAMP = TREF_DLC,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              tref_en,
  input  logic [DLC_W-1:0]  dlc,
  input  logic              big_end,
  input  logic [TMR_W-1:0]  timer,
  input  logic [CYC_W-1:0]  cyc_cnt,
  input  logic              sof,
  input  logic              byte_req,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] mb_byte,
  output logic              ser_valid,
  output logic [BYTE_W-1:0] ser_byte
);
  logic              rst_s_n;
  logic              armed;
  tref_endian_e      order;
  logic [TMR_W-1:0]  stamp;
  logic [CYC_W-1:0]  cyc;
  logic [BYTE_W-1:0] mux_byte;

  tref_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  tref_capture #(
    .TMR_W(TMR_W), .CYC_W(CYC_W), .DLC_W(DLC_W), .DLC_STAMP(DLC_STAMP)
  ) u_capture (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .sof     (sof),
    .tx_mode (tx_mode),
    .tref_en (tref_en),
    .dlc     (dlc),
    .big_end (big_end),
    .timer   (timer),
    .cyc_cnt (cyc_cnt),
    .armed   (armed),
    .order   (order),
    .stamp   (stamp),
    .cyc     (cyc)
  );

  tref_byte_mux #(
    .BYTE_W(BYTE_W), .TMR_W(TMR_W), .CYC_W(CYC_W), .IDX_W(IDX_W)
  ) u_mux (
    .armed    (armed),
    .order    (order),
    .stamp    (stamp),
    .cyc      (cyc),
    .idx      (byte_idx),
    .mb_byte  (mb_byte),
    .out_byte (mux_byte)
  );

  logic              valid_d, valid_q;
  logic [BYTE_W-1:0] byte_d,  byte_q;

  always_comb begin
    valid_d = byte_req;
    byte_d  = byte_q;
    if (byte_req) byte_d = mux_byte;  // clock enable on the data register
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      valid_q <= valid_d;
      byte_q  <= byte_d;
    end
  end

  assign ser_valid = valid_q;
  assign ser_byte  = byte_q;

  // R7: one-cycle answer to each request, silence otherwise
  a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    byte_req |=> ser_valid);
  a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
    !byte_req |=> (!ser_valid && $stable(ser_byte)));

  // R1, R2: disarmed context leaves the byte untouched
  a_r2_disarmed_passthru: assert property (@(posedge clk) disable iff (!rst_s_n)
    (byte_req && !armed) |=> (ser_byte == $past(mb_byte)));

  // R5: the high nibble of byte 0 always comes from the mailbox
  a_r5_hi_nibble: assert property (@(posedge clk) disable iff (!rst_s_n)
    (byte_req && byte_idx == IDX_W'(TREF_CYC_POS)) |=>
      (ser_byte[BYTE_W-1:CYC_W] == $past(mb_byte[BYTE_W-1:CYC_W])));

  // R6: bytes past the timer field are never rewritten
  a_r6_tail_passthru: assert property (@(posedge clk) disable iff (!rst_s_n)
    (byte_req && byte_idx >= IDX_W'(TREF_STAMP_POS + TMR_W / BYTE_W)) |=>
      (ser_byte == $past(mb_byte)));
endmodule

// File: tb/tref_inserter_bench.sv
`timescale 1ns/1ps
module tref_inserter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_mode, tref_en, big_end, sof, byte_req;
  logic [3:0]  dlc, cyc_cnt;
  logic [15:0] timer;
  logic [2:0]  byte_idx;
  logic [7:0]  mb_byte;
  logic        ser_valid;
  logic [7:0]  ser_byte;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tref_inserter u_tref_inserter (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .tref_en(tref_en), .dlc(dlc),
    .big_end(big_end), .timer(timer), .cyc_cnt(cyc_cnt), .sof(sof),
    .byte_req(byte_req), .byte_idx(byte_idx), .mb_byte(mb_byte),
    .ser_valid(ser_valid), .ser_byte(ser_byte)
  );

  // {req[3:0], tx, en, dlc[3:0], big, timer[15:0], cyc[3:0], idx[2:0], mb[7:0], exp[7:0]}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {4'd5, 1'b1, 1'b1, 4'd4, 1'b1, 16'h1234, 4'h9, 3'd0, 8'hF0, 8'hF9},  // R5
    {4'd3, 1'b1, 1'b1, 4'd4, 1'b1, 16'h1234, 4'h9, 3'd1, 8'h00, 8'h12},  // R3
    {4'd3, 1'b1, 1'b1, 4'd4, 1'b1, 16'h1234, 4'h9, 3'd2, 8'hFF, 8'h34},  // R3
    {4'd4, 1'b1, 1'b1, 4'd4, 1'b0, 16'h1234, 4'h9, 3'd1, 8'h00, 8'h34},  // R4
    {4'd4, 1'b1, 1'b1, 4'd4, 1'b0, 16'h1234, 4'h9, 3'd2, 8'h00, 8'h12},  // R4
    {4'd6, 1'b1, 1'b1, 4'd4, 1'b1, 16'hBEEF, 4'h2, 3'd3, 8'hC3, 8'hC3},  // R6
    {4'd2, 1'b1, 1'b1, 4'd5, 1'b1, 16'h1234, 4'h9, 3'd1, 8'h77, 8'h77},  // R2
    {4'd2, 1'b1, 1'b0, 4'd4, 1'b1, 16'h1234, 4'h9, 3'd2, 8'h66, 8'h66},  // R2
    {4'd2, 1'b0, 1'b1, 4'd4, 1'b1, 16'h1234, 4'h9, 3'd0, 8'hAB, 8'hAB},  // R2
    {4'd6, 1'b1, 1'b1, 4'd4, 1'b1, 16'h1234, 4'h9, 3'd5, 8'h5A, 8'h5A},  // R6
    {4'd5, 1'b1, 1'b1, 4'd4, 1'b0, 16'hA5C3, 4'h0, 3'd0, 8'h3C, 8'h30},  // R5
    {4'd4, 1'b1, 1'b1, 4'd4, 1'b0, 16'hBEEF, 4'h7, 3'd2, 8'h00, 8'hBE}   // R4
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_sof(input logic t, input logic e, input logic [3:0] d,
                        input logic b, input logic [15:0] tm, input logic [3:0] c);
    @(negedge clk);
    tx_mode = t; tref_en = e; dlc = d; big_end = b; timer = tm; cyc_cnt = c; sof = 1'b1;
    @(negedge clk);
    sof = 1'b0; timer = ~tm; cyc_cnt = ~c;  // later changes must not leak in (R3)
  endtask

  // request one byte, return the answer and check ser_valid around it (R7)
  task automatic fetch(input logic [2:0] idx, input logic [7:0] mb, output logic [7:0] got);
    @(negedge clk);
    byte_req = 1'b1; byte_idx = idx; mb_byte = mb;
    @(negedge clk);
    byte_req = 1'b0; mb_byte = ~mb;
    got = ser_byte;
    check("R7 valid after request", {7'd0, ser_valid}, 8'd1);
  endtask

  initial begin
    logic [7:0] got;
    rst_n = 1'b0; sof = 1'b0; byte_req = 1'b0; tx_mode = 1'b0; tref_en = 1'b0;
    dlc = 4'd0; big_end = 1'b0; timer = 16'h0; cyc_cnt = 4'h0; byte_idx = 3'd0; mb_byte = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and pass-through before any start of frame
    check("R1 reset valid", {7'd0, ser_valid}, 8'd0);
    check("R1 reset byte", ser_byte, 8'h00);
    fetch(3'd1, 8'h5C, got);
    check("R1 pre-sof passthru", got, 8'h5C);
    @(negedge clk);
    check("R7 valid drops", {7'd0, ser_valid}, 8'd0);
    check("R7 byte holds", ser_byte, 8'h5C);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      do_sof(v[45], v[44], v[43:40], v[39], v[38:23], v[22:19]);
      fetch(v[18:16], v[15:8], got);
      total++;
      if (got !== v[7:0]) begin
        bad++;
        $display("FAIL R%0d vector %0d: got %02h expected %02h", v[49:46], i, got, v[7:0]);
      end
    end

    // R9: configuration changes after sof do not affect the frame
    do_sof(1'b1, 1'b1, 4'd4, 1'b1, 16'h0A0B, 4'h3);
    tref_en = 1'b0; dlc = 4'd2; big_end = 1'b0; tx_mode = 1'b0;
    fetch(3'd1, 8'hEE, got);
    check("R9 byte1 unchanged by late config", got, 8'h0A);
    fetch(3'd0, 8'h90, got);
    check("R9 byte0 still stamped", got, 8'h93);

    // R8: retransmission re-samples the timer
    do_sof(1'b1, 1'b1, 4'd4, 1'b1, 16'h7788, 4'h1);
    fetch(3'd2, 8'h00, got);
    check("R8 new stamp low byte", got, 8'h88);
    fetch(3'd1, 8'h00, got);
    check("R8 new stamp high byte", got, 8'h77);

    // R8: a re-sof that fails arming disables insertion
    do_sof(1'b1, 1'b1, 4'd8, 1'b1, 16'h4242, 4'h5);
    fetch(3'd1, 8'h11, got);
    check("R8 disarmed on resample", got, 8'h11);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule